// File: doc/BRIEF.md
# Status-Decoding Bus Command Generator

This block sits beside a processor whose bus interface only reports a three-bit status code per bus cycle. It recovers the cycle type from that code and turns it into individual, active-high command strobes: memory read, memory write, I/O read, I/O write and interrupt acknowledge. It also issues early versions of the two write strobes, so that slow devices get extra access time. For the external address latch and data transceiver it produces an address latch pulse, a data enable and a transmit/receive direction.

A cycle begins when the status leaves the idle (passive) code. A cycle ends when the status returns to that code. Two enable inputs let another bus master take the bus. One of them removes the command strobes outright. The other blanks them and releases them only after a settling delay. A mode input narrows the block to serving a bus that carries only I/O devices.

Top module: `bus_cmd_gen`

## Requirements
- R1: While rst_ni is low, every output is 0.
- R2: Status codes, with status_i[2] as the MSB: 000 interrupt acknowledge, 001 I/O read, 010 I/O write, 011 halt, 100 code fetch, 101 memory read, 110 memory write, 111 passive. No more than one of mem_rd_o, mem_wr_o, io_rd_o, io_wr_o and inta_o is ever high.
- R3: A cycle starts on the first rising edge at which status_i is not 111 while the block is idle. ale_o is high for exactly the clock that follows that edge, and no command is active during that clock.
- R4: mem_rd_o, io_rd_o, inta_o, adv_mem_wr_o and adv_io_wr_o go high on the next edge. They stay high until the edge at which status_i is sampled as 111, and they drop after that edge.
- R5: mem_wr_o and io_wr_o go high WR_DELAY clocks (default 1) after their advanced versions. They drop on the same edge as the advanced versions.
- R6: den_o is high during the command phase of every cycle other than halt. dt_tx_o is high from the address clock to the end of the cycle for write codes (010, 110), and low otherwise.
- R7: A halt code (011) gives an ale_o pulse, but no command strobe and no den_o.
- R8: While cmd_en_i is low, every command output and den_o is low. ale_o and dt_tx_o are not affected.
- R9: While addr_en_i is low, every command output is low. After addr_en_i returns high, the commands stay low until AEN_SETTLE clocks (default 1) have passed, and then resume.
- R10: With io_bus_i high, the memory command outputs never assert. The I/O and interrupt-acknowledge strobes then ignore addr_en_i.
- R11: A code fetch (100) produces the same outputs as a memory read (101).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| status_i | input | 3 | Processor bus status code |
| addr_en_i | input | 1 | High when this master owns the bus |
| cmd_en_i | input | 1 | Command enable; low blanks commands and den_o |
| io_bus_i | input | 1 | I/O-only bus mode |
| ale_o | output | 1 | Address latch enable pulse |
| den_o | output | 1 | Data transceiver enable |
| dt_tx_o | output | 1 | Transceiver direction, 1 = transmit (write) |
| mem_rd_o | output | 1 | Memory read command |
| mem_wr_o | output | 1 | Memory write command |
| io_rd_o | output | 1 | I/O read command |
| io_wr_o | output | 1 | I/O write command |
| inta_o | output | 1 | Interrupt acknowledge command |
| adv_mem_wr_o | output | 1 | Advanced memory write command |
| adv_io_wr_o | output | 1 | Advanced I/O write command |

## Verification
The hardest case to reach is losing bus ownership in the middle of a write. Commands must vanish at once, stay off through the settling clock after ownership returns, and then come back while the cycle itself keeps running. The bench holds the status on a write code past the delayed-write point and drops addr_en_i between edges. It checks the outputs inside the same clock and again after an edge. It then raises the enable and samples both before and after the settling edge. The same cycle shapes are repeated with cmd_en_i low and in I/O-bus mode, to separate the three gating paths.

// File: rtl/bus_cmd_pkg.sv
package bus_cmd_pkg;
  typedef enum logic [2:0] {
    ST_INTA    = 3'b000,
    ST_IORD    = 3'b001,
    ST_IOWR    = 3'b010,
    ST_HALT    = 3'b011,
    ST_FETCH   = 3'b100,
    ST_MRD     = 3'b101,
    ST_MWR     = 3'b110,
    ST_PASSIVE = 3'b111
  } status_e;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ADDR = 2'd1,
    PH_CMD  = 2'd2
  } phase_e;

  typedef struct packed {
    logic mem_rd;
    logic mem_wr;
    logic io_rd;
    logic io_wr;
    logic inta;
  } cmd_t;
endpackage

// File: rtl/bcg_status_decode.sv
module bcg_status_decode
  import bus_cmd_pkg::*;
(
  input  status_e code_i,
  output cmd_t    req_o,
  output logic    is_write_o,
  output logic    is_halt_o
);
  always_comb begin
    req_o = '0;
    unique case (code_i)
      ST_INTA:           req_o.inta   = 1'b1;
      ST_IORD:           req_o.io_rd  = 1'b1;
      ST_IOWR:           req_o.io_wr  = 1'b1;
      ST_FETCH, ST_MRD:  req_o.mem_rd = 1'b1;
      ST_MWR:            req_o.mem_wr = 1'b1;
      default:           req_o = '0;
    endcase
  end

  assign is_write_o = (code_i == ST_IOWR) || (code_i == ST_MWR);
  assign is_halt_o  = (code_i == ST_HALT);
endmodule

// File: rtl/bcg_cycle_fsm.sv
module bcg_cycle_fsm
  import bus_cmd_pkg::*;
#(
  parameter int WR_DELAY = 1
) (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  status_e status_i,
  output phase_e  phase_o,
  output status_e code_o,
  output logic    wr_late_o
);
  localparam int CW = $clog2(WR_DELAY + 2);

  phase_e        phase_q;
  status_e       code_q;
  logic [CW-1:0] wcnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      code_q  <= ST_PASSIVE;
      wcnt_q  <= '0;
    end else begin
      unique case (phase_q)
        PH_IDLE: begin
          wcnt_q <= '0;
          if (status_i != ST_PASSIVE) begin
            phase_q <= PH_ADDR;
            code_q  <= status_i;
          end
        end
        PH_ADDR: begin
          wcnt_q  <= '0;
          phase_q <= (status_i == ST_PASSIVE) ? PH_IDLE : PH_CMD;
        end
        PH_CMD: begin
          if (status_i == ST_PASSIVE) begin
            phase_q <= PH_IDLE;
            wcnt_q  <= '0;
          end else if (wcnt_q != CW'(WR_DELAY)) begin
            wcnt_q <= wcnt_q + 1'b1;
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign phase_o   = phase_q;
  assign code_o    = code_q;
  assign wr_late_o = (phase_q == PH_CMD) && (wcnt_q == CW'(WR_DELAY));

  // R3: address phase lasts a single clock
  a_r3_ale_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_q == PH_ADDR |=> phase_q != PH_ADDR);
  // R4: passive status closes any cycle
  a_r4_passive_ends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_CMD && status_i == ST_PASSIVE) |=> phase_q == PH_IDLE);
endmodule

// File: rtl/bcg_cmd_gate.sv
module bcg_cmd_gate
  import bus_cmd_pkg::*;
#(
  parameter int AEN_SETTLE = 1
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   addr_en_i,
  input  logic   cmd_en_i,
  input  logic   io_bus_i,
  input  phase_e phase_i,
  input  cmd_t   req_i,
  input  logic   is_write_i,
  input  logic   is_halt_i,
  input  logic   wr_late_i,
  output logic   ale_o,
  output logic   den_o,
  output logic   dt_tx_o,
  output cmd_t   cmd_o,
  output logic   adv_mem_wr_o,
  output logic   adv_io_wr_o
);
  localparam int AW = $clog2(AEN_SETTLE + 2);

  logic [AW-1:0] aen_cnt_q;
  logic          aen_ok;
  logic          gate_mem, gate_io, in_cmd;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           aen_cnt_q <= '0;
    else if (!addr_en_i)                   aen_cnt_q <= '0;
    else if (aen_cnt_q != AW'(AEN_SETTLE)) aen_cnt_q <= aen_cnt_q + 1'b1;
  end

  assign aen_ok   = addr_en_i && (aen_cnt_q == AW'(AEN_SETTLE));
  assign gate_mem = cmd_en_i && aen_ok && !io_bus_i;
  assign gate_io  = cmd_en_i && (aen_ok || io_bus_i);
  assign in_cmd   = (phase_i == PH_CMD);

  always_comb begin
    cmd_o.mem_rd = in_cmd && req_i.mem_rd && gate_mem;
    cmd_o.mem_wr = wr_late_i && req_i.mem_wr && gate_mem;
    cmd_o.io_rd  = in_cmd && req_i.io_rd && gate_io;
    cmd_o.io_wr  = wr_late_i && req_i.io_wr && gate_io;
    cmd_o.inta   = in_cmd && req_i.inta && gate_io;
  end

  assign adv_mem_wr_o = in_cmd && req_i.mem_wr && gate_mem;
  assign adv_io_wr_o  = in_cmd && req_i.io_wr && gate_io;
  assign ale_o        = (phase_i == PH_ADDR);
  assign den_o        = in_cmd && !is_halt_i && cmd_en_i;
  assign dt_tx_o      = (phase_i != PH_IDLE) && is_write_i;

  // R9: no command while ownership is withheld, outside I/O-bus mode
  a_r9_aen_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!addr_en_i && !io_bus_i) |-> (cmd_o == '0 && !adv_mem_wr_o && !adv_io_wr_o));
  // R10: memory side silent on an I/O-only bus
  a_r10_iob_no_mem: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_bus_i |-> (!cmd_o.mem_rd && !cmd_o.mem_wr && !adv_mem_wr_o));
endmodule

// File: rtl/bus_cmd_gen.sv
module bus_cmd_gen
  import bus_cmd_pkg::*;
#(
  parameter int WR_DELAY   = 1,
  parameter int AEN_SETTLE = 1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [2:0] status_i,
  input  logic       addr_en_i,
  input  logic       cmd_en_i,
  input  logic       io_bus_i,
  output logic       ale_o,
  output logic       den_o,
  output logic       dt_tx_o,
  output logic       mem_rd_o,
  output logic       mem_wr_o,
  output logic       io_rd_o,
  output logic       io_wr_o,
  output logic       inta_o,
  output logic       adv_mem_wr_o,
  output logic       adv_io_wr_o
);
  phase_e  phase;
  status_e code;
  cmd_t    req, cmd;
  logic    is_write, is_halt, wr_late;

  bcg_cycle_fsm #(.WR_DELAY(WR_DELAY)) i_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .status_i  (status_e'(status_i)),
    .phase_o   (phase),
    .code_o    (code),
    .wr_late_o (wr_late)
  );

  bcg_status_decode i_dec (
    .code_i     (code),
    .req_o      (req),
    .is_write_o (is_write),
    .is_halt_o  (is_halt)
  );

  bcg_cmd_gate #(.AEN_SETTLE(AEN_SETTLE)) i_gate (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .addr_en_i    (addr_en_i),
    .cmd_en_i     (cmd_en_i),
    .io_bus_i     (io_bus_i),
    .phase_i      (phase),
    .req_i        (req),
    .is_write_i   (is_write),
    .is_halt_i    (is_halt),
    .wr_late_i    (wr_late),
    .ale_o        (ale_o),
    .den_o        (den_o),
    .dt_tx_o      (dt_tx_o),
    .cmd_o        (cmd),
    .adv_mem_wr_o (adv_mem_wr_o),
    .adv_io_wr_o  (adv_io_wr_o)
  );

  assign mem_rd_o = cmd.mem_rd;
  assign mem_wr_o = cmd.mem_wr;
  assign io_rd_o  = cmd.io_rd;
  assign io_wr_o  = cmd.io_wr;
  assign inta_o   = cmd.inta;

  // R2: at most one command strobe
  a_r2_one_cmd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({mem_rd_o, mem_wr_o, io_rd_o, io_wr_o, inta_o}));
  // R5: a normal write is always covered by its advanced write
  a_r5_wr_inside_adv: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_wr_o |-> adv_mem_wr_o) and (io_wr_o |-> adv_io_wr_o));
  // R3: no command while the address is being latched
  a_r3_ale_no_cmd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ale_o |-> !(mem_rd_o || io_rd_o || inta_o || adv_mem_wr_o || adv_io_wr_o));
  // R8: command enable removes strobes and data enable
  a_r8_cen_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_en_i |-> !(den_o || mem_rd_o || mem_wr_o || io_rd_o || io_wr_o ||
                    inta_o || adv_mem_wr_o || adv_io_wr_o));
endmodule

// File: tb/test_bus_cmd_gen.sv
module test_bus_cmd_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] status = 3'b111;
  logic       addr_en = 1'b1, cmd_en = 1'b1, io_bus = 1'b0;
  logic ale_o, den_o, dt_tx_o, mem_rd_o, mem_wr_o, io_rd_o, io_wr_o, inta_o,
        adv_mem_wr_o, adv_io_wr_o;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  bus_cmd_gen i_bus_cmd_gen (
    .clk_i(clk), .rst_ni(rst_n), .status_i(status), .addr_en_i(addr_en),
    .cmd_en_i(cmd_en), .io_bus_i(io_bus), .ale_o(ale_o), .den_o(den_o),
    .dt_tx_o(dt_tx_o), .mem_rd_o(mem_rd_o), .mem_wr_o(mem_wr_o),
    .io_rd_o(io_rd_o), .io_wr_o(io_wr_o), .inta_o(inta_o),
    .adv_mem_wr_o(adv_mem_wr_o), .adv_io_wr_o(adv_io_wr_o)
  );

  // {ale, den, dt_tx, mem_rd, mem_wr, io_rd, io_wr, inta, adv_mem_wr, adv_io_wr}
  function automatic logic [9:0] obs();
    return {ale_o, den_o, dt_tx_o, mem_rd_o, mem_wr_o, io_rd_o, io_wr_o,
            inta_o, adv_mem_wr_o, adv_io_wr_o};
  endfunction

  // ph: 0 idle, 1 address clock, 2 first command clock, 3 after write delay
  function automatic logic [9:0] expv(input logic [2:0] c, input int ph,
                                      input bit cen, input bit aok, input bit iob);
    bit wr = (c == 3'b010) || (c == 3'b110);
    bit gm = cen && aok && !iob;
    bit gi = cen && (aok || iob);
    bit cp = ph >= 2;
    bit lp = ph >= 3;
    return {ph == 1, cp && c != 3'b011 && cen, wr && ph >= 1,
            cp && (c == 3'b100 || c == 3'b101) && gm,
            lp && c == 3'b110 && gm,
            cp && c == 3'b001 && gi,
            lp && c == 3'b010 && gi,
            cp && c == 3'b000 && gi,
            cp && c == 3'b110 && gm,
            cp && c == 3'b010 && gi};
  endfunction

  task automatic chk(input string req, input logic [9:0] got, input logic [9:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", req, got, exp);
    end
  endtask

  task automatic run_cyc(input logic [2:0] c, input string req);
    @(negedge clk);
    status = c;
    chk(req, obs(), expv(c, 0, cmd_en, addr_en, io_bus));
    for (int ph = 1; ph <= 4; ph++) begin
      @(negedge clk);
      chk(req, obs(), expv(c, ph > 3 ? 3 : ph, cmd_en, addr_en, io_bus));
    end
    status = 3'b111;
    @(negedge clk);
    chk(req, obs(), expv(c, 0, cmd_en, addr_en, io_bus));
  endtask

  task automatic t_reads();
    run_cyc(3'b101, "R4 R2 memory read");
    run_cyc(3'b100, "R11 code fetch");
    run_cyc(3'b001, "R4 I/O read");
    run_cyc(3'b000, "R2 interrupt acknowledge");
  endtask

  task automatic t_writes();
    run_cyc(3'b110, "R5 R6 memory write");
    run_cyc(3'b010, "R5 R6 I/O write");
  endtask

  task automatic t_halt();
    run_cyc(3'b011, "R7 halt");
  endtask

  task automatic t_cmd_en();
    cmd_en = 1'b0;
    run_cyc(3'b110, "R8 write with cmd_en low");
    run_cyc(3'b101, "R8 read with cmd_en low");
    cmd_en = 1'b1;
  endtask

  task automatic t_aen();
    @(negedge clk);
    status = 3'b110;
    @(negedge clk); chk("R9 setup ale", obs(), expv(3'b110, 1, 1, 1, 0));
    @(negedge clk); @(negedge clk);
    chk("R9 write active", obs(), expv(3'b110, 3, 1, 1, 0));
    addr_en = 1'b0;
    #1 chk("R9 drop immediate", obs(), expv(3'b110, 3, 1, 0, 0));
    @(negedge clk); chk("R9 drop held", obs(), expv(3'b110, 3, 1, 0, 0));
    addr_en = 1'b1;
    #1 chk("R9 settle blank", obs(), expv(3'b110, 3, 1, 0, 0));
    @(negedge clk); chk("R9 resume", obs(), expv(3'b110, 3, 1, 1, 0));
    status = 3'b111;
    @(negedge clk); chk("R9 end", obs(), expv(3'b110, 0, 1, 1, 0));
  endtask

  task automatic t_iob();
    io_bus = 1'b1;
    addr_en = 1'b0;
    run_cyc(3'b101, "R10 memory read on I/O bus");
    run_cyc(3'b010, "R10 I/O write ignores addr_en");
    run_cyc(3'b000, "R10 inta ignores addr_en");
    io_bus = 1'b0;
    addr_en = 1'b1;
    @(negedge clk); @(negedge clk);
  endtask

  initial begin
    #3;
    chk("R1 reset", obs(), 10'b0);
    status = 3'b101;
    @(posedge clk); #1;
    chk("R1 reset held", obs(), 10'b0);
    @(negedge clk);
    status = 3'b111;
    rst_n = 1'b1;
    @(negedge clk); @(negedge clk);
    t_reads();
    t_writes();
    t_halt();
    t_cmd_en();
    t_aen();
    t_iob();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule